// File: doc/BRIEF.md
# Prioritised Trigger Source Arbiter

This block sits in front of a shared conversion sequencer. It watches ten trigger sources: eight general-purpose sources (indices 0 to 7) and two dedicated sources (indices 8 and 9). It remembers every trigger that arrives until that source has been served, and each time the sequencer reports that it is idle it hands the sequencer the highest-priority waiting source.

A general source fires in one of two ways. In hardware mode a rising edge on its external input fires it. In software mode a one-cycle software trigger bit fires it. The dedicated pair answers only to hardware edges. A group bypass control takes the dedicated pair out of arbitration. In bypass, the pair's raw inputs are passed straight through towards the converter.

A held software reset returns every piece of arbiter state to its reset value. This is the same effect as the synchronous active-low reset.

Top module: `trig_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_valid` is 0, `grant_idx` is 0 and `pending` is 0 on the next clock edge.
- R2: In hardware mode an enabled source becomes pending one clock after its input is first sampled high following a low sample. Holding the input high adds no further trigger.
- R3: A trigger that arrives while the same source is already pending merges into it, so the source is granted exactly once.
- R4: When several enabled sources are pending, the grant goes to the one with the largest 3-bit priority, where 7 is highest. The priority of source i is held in `prio_cfg[3*i+2:3*i]`.
- R5: Among pending sources of equal priority, the lowest source index is granted first.
- R6: A grant is issued only on a clock edge where `seq_idle` is sampled high. `grant_valid` and `grant_idx` are registered and appear one clock after that edge. The same edge clears the granted source's pending bit.
- R7: When `gen_sw_mode[n]` is 1, general source n ignores its hardware input. A one-cycle pulse on `gen_sw_wr[n]` sets a self-clearing trigger bit, and the source becomes pending one clock later.
- R8: `gen_en[n]` gates general source n. With the bit at 0, no trigger is latched for that source and the source is not granted. For example, the value 8'h07 enables sources 0, 1 and 2.
- R9: While `ded_bypass` is 1, `ded_direct` equals `ded_hw_trig` combinationally. In that state sources 8 and 9 never become pending, any pending bits they hold are cleared, and they are never granted.
- R10: While `ded_bypass` is 0, `ded_en[k]` enables dedicated source 8+k, and `ded_direct` is 0. The dedicated sources have no software trigger path.
- R11: While `soft_rst` is 1, all arbiter state returns to its reset value, exactly as for `rst_n` low.
- R12: Suppose a new trigger for a source arrives on the same edge that grants that source. The new trigger stays pending, and the source is granted again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset; holds all state at reset while high |
| gen_en | input | 8 | Enable mask of the general sources, bit n for source n |
| gen_sw_mode | input | 8 | 1 selects software trigger mode for general source n |
| gen_sw_wr | input | 8 | Software trigger write strobes for the general sources |
| gen_hw_trig | input | 8 | External trigger inputs of the general sources |
| ded_en | input | 2 | Enables of dedicated sources 8 and 9 |
| ded_hw_trig | input | 2 | External trigger inputs of the dedicated sources |
| ded_bypass | input | 1 | Removes the dedicated sources from arbitration |
| prio_cfg | input | 30 | 3-bit priority per source, source i at bits 3i+2..3i |
| seq_idle | input | 1 | Sequencer is ready to accept a grant |
| grant_valid | output | 1 | One-cycle grant to the sequencer |
| grant_idx | output | 4 | Index of the granted source; 0 when no grant |
| pending | output | 10 | Latched pending triggers, bit i for source i |
| ded_direct | output | 2 | Bypass path of the dedicated inputs to the converter |

## Verification
The bench targets several corner cases, and each one has a distinct failure signature.
- Priority ties: picking the highest index shows up as the wrong `grant_idx`.
- A trigger landing on the edge that grants the same source: a design that clears pending unconditionally loses the second request.
- Repeated edges while a source is pending: a counting design would grant twice.
- Holding an input high: a level-sensitive front end would re-arm after every grant.
- The software and hardware mode split and the enable mask: a leaky gate latches triggers that should be ignored.
- Turning bypass on over a pending dedicated source: the arbiter could still serve 8 or 9 to the sequencer.
- A held software reset: stale pending bits could survive the reset.

// File: rtl/trig_arb_pkg.sv
// Package: shared helpers for the trigger arbiter.
// Assumes priorities are packed per source in a flat vector, source 0 lowest bits.
package trig_arb_pkg;

    // Width of one per-source priority field.
    localparam int PRIO_BITS = 3;

    // Kind of a trigger source; dedicated sources are hardware-only.
    typedef enum logic {
        SRC_GENERAL   = 1'b0,
        SRC_DEDICATED = 1'b1
    } src_kind_e;

    // Number of bits needed to index n sources (at least 1).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/trig_src_front.sv
// Module: per-source trigger front end.
// Turns an external level into a single-cycle fire on a rising edge, or, in
// software mode, fires from a self-clearing software trigger bit. The source
// is gated by its enable and by a block input (bypass for the dedicated pair).
// Assumes the hardware input is already synchronous to clk.
module trig_src_front (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic block,
    input  logic sw_mode,
    input  logic sw_wr,
    input  logic hw_in,
    output logic fire
);

    logic prev_q;
    logic sw_q;
    logic rise;

    // Remember last input level and hold the self-clearing software bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q <= 1'b0;
            sw_q   <= 1'b0;
        end else begin
            prev_q <= hw_in;
            sw_q   <= sw_wr;
        end
    end

    // Detect the rising edge of the hardware input.
    assign rise = hw_in & ~prev_q;

    // Select trigger cause by mode and apply the gates.
    always_comb begin
        fire = en & ~block & (sw_mode ? sw_q : rise);
    end

endmodule

// File: rtl/trig_pend_reg.sv
// Module: pending trigger latch.
// Sets a bit on fire, clears it on grant (unless a new fire arrives on the
// same edge) and force-clears bits named by drop.
// Assumes grant_oh has at most one bit set.
module trig_pend_reg #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] fire,
    input  logic [N-1:0] grant_oh,
    input  logic [N-1:0] drop,
    output logic [N-1:0] pend
);

    logic [N-1:0] pend_q;

    // Update each pending bit from fire, grant and drop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~grant_oh) | fire) & ~drop;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/trig_prio_pick.sv
// Module: combinational priority picker.
// Finds the requesting source with the largest priority; ties resolve to the
// lowest index. Assumes priorities are packed PW bits per source.
module trig_prio_pick #(
    parameter int N     = 10,
    parameter int PW    = 3,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            any,
    output logic [IDX_W-1:0] win
);

    logic [PW-1:0] best;

    // Scan from high index to low so that equal priority favours low index.
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && (!any || prio[i*PW +: PW] >= best)) begin
                any  = 1'b1;
                best = prio[i*PW +: PW];
                win  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/trig_arbiter.sv
// Module: prioritised trigger source arbiter (top).
// Latches triggers from N_GEN general and N_DED dedicated sources and grants
// the best pending one to the shared sequencer whenever it reports idle.
// Assumes all inputs are synchronous to clk; grant outputs are registered.
module trig_arbiter
    import trig_arb_pkg::*;
#(
    parameter int N_GEN  = 8,
    parameter int N_DED  = 2,
    parameter int PRIO_W = PRIO_BITS,
    localparam int N_SRC = N_GEN + N_DED,
    localparam int IDX_W = idx_width(N_GEN + N_DED)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic [N_GEN-1:0]        gen_en,
    input  logic [N_GEN-1:0]        gen_sw_mode,
    input  logic [N_GEN-1:0]        gen_sw_wr,
    input  logic [N_GEN-1:0]        gen_hw_trig,
    input  logic [N_DED-1:0]        ded_en,
    input  logic [N_DED-1:0]        ded_hw_trig,
    input  logic                    ded_bypass,
    input  logic [N_SRC*PRIO_W-1:0] prio_cfg,
    input  logic                    seq_idle,
    output logic                    grant_valid,
    output logic [IDX_W-1:0]        grant_idx,
    output logic [N_SRC-1:0]        pending,
    output logic [N_DED-1:0]        ded_direct
);

    logic [N_SRC-1:0] fire;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] eligible;
    logic [N_SRC-1:0] grant_oh;
    logic [N_SRC-1:0] drop;
    logic             any_req;
    logic [IDX_W-1:0] win;
    logic             grant_now;
    logic             gv_q;
    logic [IDX_W-1:0] gi_q;

    // Front end for every source; the variant is chosen by source kind.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam src_kind_e KIND = (i < N_GEN) ? SRC_GENERAL : SRC_DEDICATED;
        if (KIND == SRC_GENERAL) begin : g_gen
            trig_src_front u_front (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (soft_rst),
                .en      (gen_en[i]),
                .block   (1'b0),
                .sw_mode (gen_sw_mode[i]),
                .sw_wr   (gen_sw_wr[i]),
                .hw_in   (gen_hw_trig[i]),
                .fire    (fire[i])
            );
            assign eligible[i] = pend[i] & gen_en[i];
            assign drop[i]     = 1'b0;
        end else begin : g_ded
            trig_src_front u_front (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (soft_rst),
                .en      (ded_en[i-N_GEN]),
                .block   (ded_bypass),
                .sw_mode (1'b0),
                .sw_wr   (1'b0),
                .hw_in   (ded_hw_trig[i-N_GEN]),
                .fire    (fire[i])
            );
            assign eligible[i] = pend[i] & ded_en[i-N_GEN] & ~ded_bypass;
            assign drop[i]     = ded_bypass;
        end
    end

    // Pending latch shared by all sources.
    trig_pend_reg #(.N(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .fire     (fire),
        .grant_oh (grant_oh),
        .drop     (drop),
        .pend     (pend)
    );

    // Priority selection over eligible pending sources.
    trig_prio_pick #(.N(N_SRC), .PW(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .req  (eligible),
        .prio (prio_cfg),
        .any  (any_req),
        .win  (win)
    );

    // Decide whether a grant is issued on this edge and which bit it clears.
    always_comb begin
        grant_now = seq_idle & any_req;
        grant_oh  = '0;
        if (grant_now) begin
            grant_oh[win] = 1'b1;
        end
    end

    // Register the grant towards the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gv_q <= 1'b0;
            gi_q <= '0;
        end else begin
            gv_q <= grant_now;
            gi_q <= grant_now ? win : '0;
        end
    end

    // Pass dedicated inputs straight on while bypassed.
    always_comb begin
        ded_direct = ded_bypass ? ded_hw_trig : '0;
    end

    assign grant_valid = gv_q;
    assign grant_idx   = gi_q;
    assign pending     = pend;

endmodule

// File: rtl/trig_arbiter_chk.sv
// Module: assertion checker for trig_arbiter, attached by bind below.
// Assumes the top's registered grant timing.
module trig_arbiter_chk #(
    parameter int N_GEN = 8,
    parameter int N_SRC = 10,
    parameter int IDX_W = 4,
    parameter int N_DED = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             seq_idle,
    input logic             ded_bypass,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_idx,
    input logic [N_SRC-1:0] pending
);

    // R6
    grant_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(seq_idle));

    // R6
    grant_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((($past(pending) >> grant_idx) & N_SRC'(1)) != '0));

    // R4
    grant_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_idx < IDX_W'(N_SRC)));

    // R9
    bypass_no_ded_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(ded_bypass)) |-> (grant_idx < IDX_W'(N_GEN)));

    // R9
    bypass_no_ded_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ded_bypass) |-> (pending[N_SRC-1:N_GEN] == '0));

    // R11
    soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (pending == '0 && !grant_valid));

endmodule

bind trig_arbiter trig_arbiter_chk #(
    .N_GEN (N_GEN),
    .N_SRC (N_SRC),
    .IDX_W (IDX_W),
    .N_DED (N_DED)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .seq_idle    (seq_idle),
    .ded_bypass  (ded_bypass),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .pending     (pending)
);

// File: tb/trig_arbiter_tb.sv
module trig_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 8;
    localparam int ND = 2;
    localparam int NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [7:0]  gen_en = '0;
    logic [7:0]  gen_sw_mode = '0;
    logic [7:0]  gen_sw_wr = '0;
    logic [7:0]  gen_hw_trig = '0;
    logic [1:0]  ded_en = '0;
    logic [1:0]  ded_hw_trig = '0;
    logic        ded_bypass = 1'b0;
    logic [29:0] prio_cfg = '0;
    logic        seq_idle = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_idx;
    logic [9:0]  pending;
    logic [1:0]  ded_direct;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .gen_en(gen_en), .gen_sw_mode(gen_sw_mode), .gen_sw_wr(gen_sw_wr),
        .gen_hw_trig(gen_hw_trig), .ded_en(ded_en), .ded_hw_trig(ded_hw_trig),
        .ded_bypass(ded_bypass), .prio_cfg(prio_cfg), .seq_idle(seq_idle),
        .grant_valid(grant_valid), .grant_idx(grant_idx),
        .pending(pending), .ded_direct(ded_direct)
    );

    // Behavioural reference model state.
    bit m_pend [NS];
    bit m_prev [NS];
    bit m_sw   [NG];
    bit m_gv;
    int m_gidx;

    function automatic int prio_of(int i);
        return int'(prio_cfg[i*3 +: 3]);
    endfunction

    function automatic bit enabled(int i);
        return (i < NG) ? gen_en[i] : ded_en[i-NG];
    endfunction

    function automatic bit hw_level(int i);
        return (i < NG) ? gen_hw_trig[i] : ded_hw_trig[i-NG];
    endfunction

    always @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
            for (int i = 0; i < NG; i++) m_sw[i] = 0;
            m_gv = 0; m_gidx = 0;
        end else begin
            int best;
            int bestp;
            bit fires [NS];
            best = -1; bestp = -1;
            for (int i = 0; i < NS; i++) begin
                bit el;
                el = m_pend[i] && enabled(i) && !(i >= NG && ded_bypass);
                if (el && prio_of(i) > bestp) begin best = i; bestp = prio_of(i); end
            end
            for (int i = 0; i < NS; i++) begin
                if (i < NG)
                    fires[i] = gen_en[i] && (gen_sw_mode[i] ? m_sw[i] : (hw_level(i) && !m_prev[i]));
                else
                    fires[i] = !ded_bypass && ded_en[i-NG] && hw_level(i) && !m_prev[i];
            end
            m_gv   = seq_idle && (best >= 0);
            m_gidx = m_gv ? best : 0;
            for (int i = 0; i < NS; i++) begin
                if (m_gv && i == best) m_pend[i] = 0;
                if (fires[i]) m_pend[i] = 1;
                if (i >= NG && ded_bypass) m_pend[i] = 0;
                m_prev[i] = hw_level(i);
            end
            for (int i = 0; i < NG; i++) m_sw[i] = gen_sw_wr[i];
        end
    end

    function automatic logic [9:0] model_pend();
        logic [9:0] v;
        for (int i = 0; i < NS; i++) v[i] = m_pend[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one clock and compare every output against the model.
    task automatic tick();
        logic [1:0] dd;
        @(posedge clk);
        #1;
        dd = ded_bypass ? ded_hw_trig : 2'b00;
        chk(grant_valid == m_gv, cur_req, "grant_valid", int'(grant_valid), int'(m_gv));
        chk(int'(grant_idx) == m_gidx, cur_req, "grant_idx", int'(grant_idx), m_gidx);
        chk(pending == model_pend(), cur_req, "pending", int'(pending), int'(model_pend()));
        chk(ded_direct == dd, cur_req, "ded_direct", int'(ded_direct), int'(dd));
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        ticks(3);
        chk(grant_valid == 0 && pending == 0 && grant_idx == 0, "R1", "reset outputs",
            int'(pending), 0);
        rst_n = 1'b1;
        gen_en = 8'hFF; ded_en = 2'b11;
        ticks(2);

        // R2: edge latch, held level does not re-fire
        cur_req = "R2";
        gen_hw_trig[3] = 1'b1; tick();
        chk(pending == 10'h008, "R2", "edge latched", int'(pending), 'h008);
        ticks(3);
        // R3: repeated edge merges
        cur_req = "R3";
        gen_hw_trig[3] = 1'b0; tick();
        gen_hw_trig[3] = 1'b1; tick();
        chk(pending == 10'h008, "R3", "merged pending", int'(pending), 'h008);
        seq_idle = 1'b1; tick();
        chk(grant_valid && grant_idx == 3, "R3", "grant idx", int'(grant_idx), 3);
        tick();
        chk(!grant_valid && pending == 0, "R3", "single grant", int'(grant_valid), 0);
        seq_idle = 1'b0; gen_hw_trig = '0; tick();

        // R5: tie resolves to lowest index; R4 lower priority after
        cur_req = "R5";
        prio_cfg[1*3 +: 3] = 3'd5; prio_cfg[6*3 +: 3] = 3'd5; prio_cfg[2*3 +: 3] = 3'd2;
        gen_hw_trig = 8'b0100_0110; tick();
        gen_hw_trig = '0;
        // R6: no grant while sequencer busy
        cur_req = "R6";
        ticks(3);
        chk(!grant_valid && pending == 10'h046, "R6", "held while busy", int'(pending), 'h046);
        cur_req = "R5";
        seq_idle = 1'b1; tick();
        chk(grant_idx == 1, "R5", "tie low index", int'(grant_idx), 1);
        tick();
        chk(grant_idx == 6, "R5", "tie second", int'(grant_idx), 6);
        cur_req = "R4";
        tick();
        chk(grant_idx == 2, "R4", "lower prio last", int'(grant_idx), 2);
        seq_idle = 1'b0; tick();

        // R4: dedicated source with top priority beats source 0
        prio_cfg[9*3 +: 3] = 3'd7;
        gen_hw_trig[0] = 1'b1; ded_hw_trig[1] = 1'b1; tick();
        gen_hw_trig[0] = 1'b0; ded_hw_trig[1] = 1'b0;
        seq_idle = 1'b1; tick();
        chk(grant_idx == 9, "R4", "highest prio", int'(grant_idx), 9);
        tick();
        chk(grant_idx == 0, "R4", "then low prio", int'(grant_idx), 0);
        seq_idle = 1'b0; tick();

        // R7: software mode ignores hardware, fires from strobe
        cur_req = "R7";
        gen_sw_mode[4] = 1'b1;
        gen_hw_trig[4] = 1'b1; ticks(2);
        chk(pending == 0, "R7", "hw ignored in sw mode", int'(pending), 0);
        gen_sw_wr[4] = 1'b1; tick();
        gen_sw_wr[4] = 1'b0; tick();
        chk(pending == 10'h010, "R7", "sw fire", int'(pending), 'h010);
        ticks(2);
        chk(pending == 10'h010, "R7", "sw bit self-clears", int'(pending), 'h010);
        seq_idle = 1'b1; tick();
        chk(grant_idx == 4, "R7", "sw grant", int'(grant_idx), 4);
        seq_idle = 1'b0; gen_hw_trig = '0; gen_sw_mode = '0; tick();

        // R8: disabled source ignored
        cur_req = "R8";
        gen_en = 8'h07;
        gen_hw_trig[5] = 1'b1; gen_hw_trig[2] = 1'b1; tick();
        chk(pending == 10'h004, "R8", "mask 0x07", int'(pending), 'h004);
        seq_idle = 1'b1; ticks(2);
        chk(!grant_valid && pending == 0, "R8", "disabled not granted", int'(pending), 0);
        seq_idle = 1'b0; gen_hw_trig = '0; gen_en = 8'hFF; tick();

        // R10: dedicated individual enables
        cur_req = "R10";
        ded_en = 2'b01; ded_hw_trig = 2'b11; tick();
        chk(pending == 10'h100, "R10", "ded enable", int'(pending), 'h100);
        ded_hw_trig = 2'b00; ded_en = 2'b11; tick();

        // R9: bypass clears and excludes dedicated, passes through
        cur_req = "R9";
        ded_bypass = 1'b1; ded_hw_trig = 2'b11; #1;
        chk(ded_direct == 2'b11, "R9", "passthrough", int'(ded_direct), 3);
        seq_idle = 1'b1; tick();
        chk(!grant_valid && pending == 0, "R9", "bypass excludes", int'(pending), 0);
        ded_hw_trig = 2'b00; ticks(2);
        ded_bypass = 1'b0; seq_idle = 1'b0; tick();

        // R12: new edge on the granting edge stays pending
        cur_req = "R12";
        gen_hw_trig[7] = 1'b1; tick();
        gen_hw_trig[7] = 1'b0; tick();
        gen_hw_trig[7] = 1'b1; seq_idle = 1'b1; tick();
        chk(grant_valid && grant_idx == 7 && pending == 10'h080, "R12", "re-pend on grant",
            int'(pending), 'h080);
        tick();
        chk(grant_valid && grant_idx == 7, "R12", "granted again", int'(grant_idx), 7);
        seq_idle = 1'b0; gen_hw_trig = '0; tick();

        // R11: soft reset
        cur_req = "R11";
        gen_hw_trig = 8'hF0; tick();
        soft_rst = 1'b1; ticks(2);
        chk(pending == 0 && !grant_valid, "R11", "soft reset clears", int'(pending), 0);
        soft_rst = 1'b0; gen_hw_trig = '0; tick();

        // R4: random mixed traffic against the model
        cur_req = "R4";
        for (int c = 0; c < 3000; c++) begin
            gen_hw_trig = 8'($urandom);
            ded_hw_trig = 2'($urandom);
            gen_sw_wr   = 8'($urandom);
            seq_idle    = ($urandom % 3) == 0;
            if (c % 200 == 0) begin
                gen_en      = 8'($urandom);
                gen_sw_mode = 8'($urandom);
                ded_en      = 2'($urandom);
                ded_bypass  = ($urandom % 4) == 0;
                prio_cfg    = 30'($urandom);
            end
            soft_rst = ($urandom % 97) == 0;
            tick();
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule